// File: doc/BRIEF.md
# Page Map and Protection Unit

This unit sits between an address generator and main memory. It keeps one frame number for each of 32 virtual pages and a 32-bit operand-protection mask with one bit per page. For every access request it forms the physical address from the page's frame and the in-page offset. It also decides whether the access must be refused. Operands are refused when the page's protection bit is set. Instruction fetches in user mode are refused when the page maps to frame 0.

Software fills the frame table eight times, once per group of four pages. Each fill uses one 48-bit word in which the four 10-bit frame numbers are spread over non-adjacent bit fields. Each unpacked frame is trimmed to the number of installed memory pages. The protection mask is replaced one byte per write, from a fixed 8-bit field of the same data word. Results come back one clock after the request. A request made in the same cycle as a table or mask write sees the contents from before that write.

Top module: `page_xlate_unit`

## Requirements
- R1: After synchronous active-low reset, every frame entry and every protection bit is 0, and `rsp_valid` and `fault` are 0.
- R2: A map write with `map_idx` = i loads pages 4i, 4i+1, 4i+2 and 4i+3 from `wr_word`. The other 28 pages keep their frames.
- R3: For sub-page k (0..3) of the group, frame bits 4:0 come from `wr_word[5k+4:5k]`. Frame bit 5+j comes from `wr_word[28+4j+k]`, for j = 0..4.
- R4: Each unpacked frame is ANDed with `MEM_PAGES-1`, so frame bits beyond the installed memory read back as 0.
- R5: A protection write with `prot_idx` = i replaces byte i (bits 8i+7:8i) of the protection mask with `wr_word[27:20]`. The other bytes are unchanged.
- R6: An operand access (`acc_fetch`=0) faults when mask bit `acc_addr[14:10]` is 1, except in two cases. It does not fault when `prot_off`=1. It also does not fault when `supervisor`=1, `map_off`=1 and `acc_addr` < 8 all hold together.
- R7: An instruction fetch (`acc_fetch`=1) faults when `supervisor`=0 and the page's frame is 0. It never faults when `supervisor`=1, and the protection mask does not affect it.
- R8: Every response reports `fault_page` = `acc_addr[14:10]` of the request.
- R9: With `map_off`=0, `phys_addr` = {frame of page `acc_addr[14:10]`, `acc_addr[9:0]`}. With `map_off`=1, `phys_addr` is `acc_addr` zero-extended.
- R10: A request with `acc_valid`=1 produces `rsp_valid`=1 and its `fault`, `phys_addr` and `fault_page` on the next clock. A cycle without a request yields `rsp_valid`=0 and `fault`=0 on the next clock.
- R11: An access requested in the same cycle as a map or protection write is judged against the frame table and mask as they stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_word | input | 48 | Data word for map and protection writes |
| map_we | input | 1 | Load four frame entries from `wr_word` |
| map_idx | input | 3 | Page group selected for the map write |
| prot_we | input | 1 | Load one protection byte from `wr_word[27:20]` |
| prot_idx | input | 2 | Byte of the protection mask to replace |
| acc_valid | input | 1 | Access request |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| acc_addr | input | 15 | Virtual address: page in 14:10, offset in 9:0 |
| supervisor | input | 1 | Supervisor mode |
| prot_off | input | 1 | Operand protection disabled |
| map_off | input | 1 | Address mapping disabled |
| rsp_valid | output | 1 | Response of the previous cycle's request |
| phys_addr | output | 20 | Physical address |
| fault | output | 1 | Protection fault for the response |
| fault_page | output | 5 | Page number of the response |

## Verification
The case that needs care is a table or mask write landing in the same cycle as an access to a page that this write changes. The bench provokes it by raising `map_we` or `prot_we` together with `acc_valid` for a page in the affected group or byte. It then expects the response to carry the old frame or old protection bit. A second access one cycle later must show the new value. Outside this case, the bench sweeps all 32 pages under every combination of mode bits. It uses a reduced installed-memory size, so the frame trimming is visible.

// File: rtl/page_xlate_pkg.sv
// Shared constants and types of the page translation unit.
// Assumes a fixed 10-bit frame field and a 10-bit in-page offset.
package page_xlate_pkg;
    localparam int FRAME_W  = 10;
    localparam int OFS_W    = 10;
    localparam int WORD_W   = 48;
    localparam int LANES    = 4;   // frames packed into one map word
    localparam int LO_BITS  = 5;   // contiguous low frame bits per lane
    localparam int HI_BASE  = 28;  // first scattered high bit
    typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/page_map_regs.sv
// Frame table: holds one frame number per page and loads four entries at once
// from a packed data word. Assumes PAGES is a multiple of LANES.
module page_map_regs
    import page_xlate_pkg::*;
#(
    parameter int PAGES     = 32,
    parameter int MEM_PAGES = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          map_we,
    input  logic [$clog2(PAGES/LANES)-1:0] map_idx,
    input  logic [WORD_W-1:0]             wr_word,
    input  logic [$clog2(PAGES)-1:0]      rd_page,
    output frame_t                        rd_frame
);
    localparam int     PG_W = $clog2(PAGES);
    localparam frame_t MASK = frame_t'(MEM_PAGES - 1);

    logic [PAGES-1:0][FRAME_W-1:0] tbl;
    frame_t                        lane_frame [LANES];

    // Unpack each lane from its scattered fields, then trim to installed memory.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        frame_t raw;
        always_comb begin
            raw = '0;
            raw[LO_BITS-1:0] = wr_word[LO_BITS*k +: LO_BITS];
            for (int j = 0; j < FRAME_W - LO_BITS; j++)
                raw[LO_BITS+j] = wr_word[HI_BASE + LANES*j + k];
            lane_frame[k] = raw & MASK;
        end
    end

    // Store the four lanes into the selected page group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl <= '0;
        end else if (map_we) begin
            for (int k = 0; k < LANES; k++)
                tbl[{map_idx, 2'(k)}] <= lane_frame[k];
        end
    end

    // Read port used by the access path.
    assign rd_frame = tbl[rd_page];

    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !map_we |=> $stable(tbl)); // R2

    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame & ~MASK) == '0); // R4
endmodule

// File: rtl/prot_mask_reg.sv
// Operand-protection mask: one bit per page, replaced one byte per write from
// a fixed field of the data word. Assumes PROT_W is a multiple of 8.
module prot_mask_reg
    import page_xlate_pkg::*;
#(
    parameter int PROT_W  = 32,
    parameter int SRC_LSB = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         prot_we,
    input  logic [$clog2(PROT_W/8)-1:0]  prot_idx,
    input  logic [WORD_W-1:0]            wr_word,
    output logic [PROT_W-1:0]            prot_q
);
    localparam int NBYTES = PROT_W / 8;

    // One register byte per slice, loaded only when its index is selected.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                prot_q[8*b +: 8] <= '0;
            else if (prot_we && prot_idx == b)
                prot_q[8*b +: 8] <= wr_word[SRC_LSB +: 8];
        end
    end

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_we |=> $stable(prot_q)); // R5
endmodule

// File: rtl/xlate_check.sv
// Combinational translation and fault decision for one access.
// Assumes frame and mask inputs reflect the state before any same-cycle write.
module xlate_check
    import page_xlate_pkg::*;
#(
    parameter int PAGES = 32
) (
    input  logic [$clog2(PAGES)+OFS_W-1:0] acc_addr,
    input  logic                           acc_fetch,
    input  logic                           supervisor,
    input  logic                           prot_off,
    input  logic                           map_off,
    input  frame_t                         frame,
    input  logic [PAGES-1:0]               prot_q,
    output logic [FRAME_W+OFS_W-1:0]       phys_next,
    output logic                           fault_next
);
    localparam int PG_W   = $clog2(PAGES);
    localparam int ADDR_W = PG_W + OFS_W;

    logic [PG_W-1:0] page;
    logic            low_addr;
    logic            op_fault;
    logic            fetch_fault;

    // Split the address and decide both fault kinds.
    always_comb begin
        page        = acc_addr[ADDR_W-1:OFS_W];
        low_addr    = (acc_addr[ADDR_W-1:3] == '0);
        op_fault    = !acc_fetch && prot_q[page] && !prot_off
                      && !(supervisor && map_off && low_addr);
        fetch_fault = acc_fetch && !supervisor && (frame == '0);
        fault_next  = op_fault || fetch_fault;
    end

    // Form the physical address, bypassing the table when mapping is off.
    always_comb begin
        if (map_off)
            phys_next = (FRAME_W+OFS_W)'(acc_addr);
        else
            phys_next = {frame, acc_addr[OFS_W-1:0]};
    end
endmodule

// File: rtl/page_xlate_unit.sv
// Top of the page translation unit: frame table, protection mask, access
// check and a one-cycle registered response. Assumes one request per cycle.
module page_xlate_unit
    import page_xlate_pkg::*;
#(
    parameter int PAGES     = 32,
    parameter int MEM_PAGES = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_W-1:0]             wr_word,
    input  logic                          map_we,
    input  logic [$clog2(PAGES/LANES)-1:0] map_idx,
    input  logic                          prot_we,
    input  logic [$clog2(PAGES/8)-1:0]    prot_idx,
    input  logic                          acc_valid,
    input  logic                          acc_fetch,
    input  logic [$clog2(PAGES)+OFS_W-1:0] acc_addr,
    input  logic                          supervisor,
    input  logic                          prot_off,
    input  logic                          map_off,
    output logic                          rsp_valid,
    output logic [FRAME_W+OFS_W-1:0]      phys_addr,
    output logic                          fault,
    output logic [$clog2(PAGES)-1:0]      fault_page
);
    localparam int PG_W   = $clog2(PAGES);
    localparam int ADDR_W = PG_W + OFS_W;
    localparam int PHYS_W = FRAME_W + OFS_W;

    frame_t             frame;
    logic [PAGES-1:0]   prot_q;
    logic [PHYS_W-1:0]  phys_next;
    logic               fault_next;

    page_map_regs #(.PAGES(PAGES), .MEM_PAGES(MEM_PAGES)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_we   (map_we),
        .map_idx  (map_idx),
        .wr_word  (wr_word),
        .rd_page  (acc_addr[ADDR_W-1:OFS_W]),
        .rd_frame (frame)
    );

    prot_mask_reg #(.PROT_W(PAGES)) u_prot (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_we  (prot_we),
        .prot_idx (prot_idx),
        .wr_word  (wr_word),
        .prot_q   (prot_q)
    );

    xlate_check #(.PAGES(PAGES)) u_chk (
        .acc_addr   (acc_addr),
        .acc_fetch  (acc_fetch),
        .supervisor (supervisor),
        .prot_off   (prot_off),
        .map_off    (map_off),
        .frame      (frame),
        .prot_q     (prot_q),
        .phys_next  (phys_next),
        .fault_next (fault_next)
    );

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            fault      <= 1'b0;
            phys_addr  <= '0;
            fault_page <= '0;
        end else begin
            rsp_valid <= acc_valid;
            fault     <= acc_valid && fault_next;
            if (acc_valid) begin
                phys_addr  <= phys_next;
                fault_page <= acc_addr[ADDR_W-1:OFS_W];
            end
        end
    end

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!rsp_valid && !fault)); // R10

    AST_SUP_FETCH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_fetch && supervisor) |=> !fault); // R7

    AST_PROT_OFF_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_fetch && prot_off) |=> !fault); // R6

    AST_PAGE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (fault_page == $past(acc_addr[ADDR_W-1:OFS_W]))); // R8
endmodule

// File: tb/tb_page_xlate_unit.sv
// Sweeps all pages and mode combinations with a reduced installed memory.
module tb_page_xlate_unit;
    localparam int MEMP = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] wr_word = '0;
    logic        map_we = 1'b0;
    logic [2:0]  map_idx = '0;
    logic        prot_we = 1'b0;
    logic [1:0]  prot_idx = '0;
    logic        acc_valid = 1'b0;
    logic        acc_fetch = 1'b0;
    logic [14:0] acc_addr = '0;
    logic        supervisor = 1'b0;
    logic        prot_off = 1'b0;
    logic        map_off = 1'b0;
    logic        rsp_valid;
    logic [19:0] phys_addr;
    logic        fault;
    logic [4:0]  fault_page;

    page_xlate_unit #(.PAGES(32), .MEM_PAGES(MEMP)) dut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [9:0]  mdl_frame [32];
    logic [31:0] mdl_prot;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] unpack(input logic [47:0] w, input int k);
        logic [9:0] f;
        f[4:0] = w[5*k +: 5];
        for (int j = 0; j < 5; j++) f[5+j] = w[28 + 4*j + k];
        return f & 10'(MEMP - 1);
    endfunction

    task automatic map_write(input int g, input logic [47:0] w);
        @(negedge clk);
        map_we = 1'b1; map_idx = 3'(g); wr_word = w;
        @(negedge clk);
        map_we = 1'b0;
        for (int k = 0; k < 4; k++) mdl_frame[4*g+k] = unpack(w, k);
    endtask

    task automatic prot_write(input int b, input logic [7:0] v);
        @(negedge clk);
        prot_we = 1'b1; prot_idx = 2'(b); wr_word = 48'(v) << 20;
        @(negedge clk);
        prot_we = 1'b0;
        mdl_prot[8*b +: 8] = v;
    endtask

    // One request, response checked at the following negedge.
    task automatic access(input logic f, input logic sup, input logic po,
                          input logic mo, input logic [14:0] a, input string req);
        logic [4:0]  pg;
        logic        ef;
        logic [19:0] ep;
        pg = a[14:10];
        if (f) ef = !sup && (mdl_frame[pg] == 0);
        else   ef = mdl_prot[pg] && !po && !(sup && mo && a < 8);
        ep = mo ? 20'(a) : {mdl_frame[pg], a[9:0]};
        @(negedge clk);
        acc_valid = 1'b1; acc_fetch = f; supervisor = sup; prot_off = po;
        map_off = mo; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        chk({req, " rsp_valid R10"}, 32'(rsp_valid), 1);
        chk({req, " fault"}, 32'(fault), 32'(ef));
        chk({req, " phys R9"}, 32'(phys_addr), 32'(ep));
        chk({req, " page R8"}, 32'(fault_page), 32'(pg));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] w;
        logic [47:0] w_old;
        for (int p = 0; p < 32; p++) mdl_frame[p] = '0;
        mdl_prot = '0;
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 fault", 32'(fault), 0);
        rst_n = 1'b1;
        // R1: reset table is all zero frames, so user fetch faults, operand does not
        access(1'b1, 1'b0, 1'b0, 1'b0, 15'h2C07, "R1 R7 fetch after reset");
        access(1'b0, 1'b0, 1'b0, 1'b0, 15'h7FFF, "R1 R6 operand after reset");

        // R2 R3 R4: fill all groups; group 0 lane 1 is zero, group 1 lane 2 only above mask
        for (int g = 0; g < 8; g++) begin
            w = 48'(64'h9E3779B97F4A7C15 * (g + 3));
            if (g == 0) begin
                w[9:5] = '0;
                for (int j = 0; j < 5; j++) w[28 + 4*j + 1] = 1'b0;
            end
            if (g == 1) begin
                w[14:10] = '0;
                for (int j = 0; j < 5; j++) w[28 + 4*j + 2] = (j >= 3);
            end
            map_write(g, w);
        end
        for (int p = 0; p < 32; p++)
            access(1'b0, 1'b0, 1'b0, 1'b0, {5'(p), 10'(p * 37 + 5)}, "R2 R3 R4 operand sweep");
        for (int p = 0; p < 32; p++) begin
            access(1'b1, 1'b0, 1'b0, 1'b0, {5'(p), 10'h155}, "R7 R4 user fetch");
            access(1'b1, 1'b1, 1'b0, 1'b0, {5'(p), 10'h2AA}, "R7 supervisor fetch");
        end

        // R2: rewrite group 5 only; other groups must keep their frames
        map_write(5, 48'hFEDC_BA98_7654);
        for (int p = 0; p < 32; p++)
            access(1'b0, 1'b0, 1'b0, 1'b0, {5'(p), 10'h0F0}, "R2 untouched groups");

        // R5 R6: protection bytes and every mode combination
        prot_write(0, 8'hA5);
        prot_write(1, 8'h3C);
        prot_write(2, 8'hFF);
        prot_write(3, 8'h81);
        prot_write(2, 8'h5A);
        for (int p = 0; p < 32; p++)
            for (int m = 0; m < 16; m++)
                access(1'b0, m[0], m[1], m[2], {5'(p), (m[3] ? 10'd3 : 10'h1F1)},
                       "R5 R6 protection sweep");
        // R7: mask has no effect on fetches
        for (int p = 0; p < 32; p++)
            access(1'b1, 1'b0, 1'b0, 1'b0, {5'(p), 10'd9}, "R7 fetch ignores mask");

        // R10: idle cycle yields no response
        @(negedge clk);
        chk("R10 idle rsp_valid", 32'(rsp_valid), 0);
        chk("R10 idle fault", 32'(fault), 0);

        // R11: map write together with an access to a page in that group
        w_old = 48'h1111_2222_3333;
        map_write(3, w_old);
        w = 48'h0000_0000_7C00;
        @(negedge clk);
        map_we = 1'b1; map_idx = 3'd3; wr_word = w;
        acc_valid = 1'b1; acc_fetch = 1'b0; supervisor = 1'b0; prot_off = 1'b1;
        map_off = 1'b0; acc_addr = {5'd14, 10'h011};
        @(negedge clk);
        map_we = 1'b0; acc_valid = 1'b0;
        chk("R11 same-cycle map old frame", 32'(phys_addr), 32'({unpack(w_old, 2), 10'h011}));
        for (int k = 0; k < 4; k++) mdl_frame[12+k] = unpack(w, k);
        access(1'b0, 1'b0, 1'b1, 1'b0, {5'd14, 10'h011}, "R11 after map write");

        // R11: protection write together with an operand access to that byte
        @(negedge clk);
        prot_we = 1'b1; prot_idx = 2'd1; wr_word = 48'hFF << 20;
        acc_valid = 1'b1; acc_fetch = 1'b0; supervisor = 1'b0; prot_off = 1'b0;
        map_off = 1'b0; acc_addr = {5'd8, 10'h0};
        @(negedge clk);
        prot_we = 1'b0; acc_valid = 1'b0;
        chk("R11 same-cycle prot old bit", 32'(fault), 32'(mdl_prot[8]));
        mdl_prot[15:8] = 8'hFF;
        access(1'b0, 1'b0, 1'b0, 1'b0, {5'd8, 10'h0}, "R11 after prot write");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule